// File: doc/BRIEF.md
# USB Host Controller Command, Status and Interrupt Core

This block holds the software-visible control state of a full/low-speed USB host controller. It keeps a command register, a status register, an interrupt enable register, an 11-bit frame counter and a 4 KiB-aligned frame list base. While the controller runs, it produces a frame tick every `TICK_CYCLES` clocks. It also presents the address of the frame list entry that belongs to the current frame, and drives one level-sensitive interrupt line.

The schedule engine reports its results as one-cycle event pulses. Transaction errors, host system errors and process errors are posted to status at once. Completion and short-packet events are only gathered as pending during a frame. They move into status, and into a hidden two-bit cause register, at the next frame tick. A resume request is honoured only while global suspend is being entered. Register access is a flat bus: a 3-bit register index, a write strobe, write data, and read data returned in the same cycle.

The register index map is: 0 command, 1 status, 2 interrupt enable, 3 frame number, 4 frame list base, 5 current entry address (read only).

Top module: `uhc_reg_core`

## Requirements
- R1: After reset, command reads 0x00, status reads 0x20 (halted only), interrupt enable reads 0, frame number reads 0, base reads 0 and `irq` is low.
- R2: Command bit 0 is run/stop. Writing it from 0 to 1 clears status bit 5 (halted), and writing it as 0 sets halted. Writes to status never change bit 5.
- R3: While run is set, the frame number advances by one modulo 2048 once every `TICK_CYCLES` clocks. The first advance comes `TICK_CYCLES` clocks after the write that set run. While run is clear, the frame number does not move.
- R4: A pulse on `evtComplete` or `evtShort` does not touch status during its frame. At the next frame tick, status bit 0 is set and the hidden cause bit is set: bit 0 for completion, bit 1 for short packet.
- R5: The frame number register takes a write only while halted, and it keeps only the low 11 bits. A write while running is ignored.
- R6: The base register keeps write-data bits 31:12 and reads its low 12 bits as zero. Register 5 and `frameAddr` equal the base plus the low 10 frame-number bits times 4.
- R7: `irq` is high when any of these holds: hidden bit 0 with enable bit 2; hidden bit 1 with enable bit 3; status bit 1 with enable bit 0; status bit 2 with enable bit 1; status bit 3; status bit 4.
- R8: Writing 1 to any of status bits 0 to 4 clears that bit. Writing 1 to status bit 0 also clears both hidden cause bits.
- R9: While command bit 3 (enter global suspend) is set, `evtResume` sets command bit 4 (force global resume) and status bit 2 (resume detect). When command bit 3 is clear, `evtResume` has no effect.
- R10: Writing command with bit 1 set returns every register to its R1 value on the next clock.
- R11: `evtError`, `evtSysErr` and `evtProcErr` set status bits 1, 3 and 4 respectively on the next clock, without waiting for a frame tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register index |
| regWe | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| evtComplete | input | 1 | Completion-with-interrupt event pulse |
| evtShort | input | 1 | Short-packet event pulse |
| evtError | input | 1 | Transaction error event pulse |
| evtResume | input | 1 | Resume request pulse |
| evtSysErr | input | 1 | Host system error pulse |
| evtProcErr | input | 1 | Schedule process error pulse |
| frameAddr | output | 32 | Frame list entry address for the current frame |
| frameTick | output | 1 | One-cycle pulse at each frame boundary |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong internal state shows up at the ports within one frame at most.

- A lost or stale pending bit changes status bit 0 and `irq` at the first tick after the event.
- A hidden cause register that is not cleared keeps `irq` high right after a status bit 0 write-one-to-clear, on the next clock.
- An off-by-one in the tick counter moves the first frame-number step by a clock. The bench therefore samples it exactly `TICK_CYCLES` clocks after run is set.
- A run/halted mismatch is visible in the status read as soon as the command write retires.

// File: rtl/uhc_reg_pkg.sv
package uhc_reg_pkg;

  localparam logic [2:0] ADR_CMD   = 3'd0;
  localparam logic [2:0] ADR_STS   = 3'd1;
  localparam logic [2:0] ADR_IEN   = 3'd2;
  localparam logic [2:0] ADR_FRN   = 3'd3;
  localparam logic [2:0] ADR_BASE  = 3'd4;
  localparam logic [2:0] ADR_ENTRY = 3'd5;

  // command bit positions
  localparam int CMD_RUN   = 0;
  localparam int CMD_HCRST = 1;
  localparam int CMD_EGS   = 3;
  localparam int CMD_FGR   = 4;

  // status bit positions
  localparam int STS_INT  = 0;
  localparam int STS_ERR  = 1;
  localparam int STS_RES  = 2;
  localparam int STS_SYS  = 3;
  localparam int STS_PROC = 4;
  localparam int STS_HALT = 5;

  localparam logic [5:0] STS_RESET = 6'h20;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic hcReset;
    logic runRise;
    logic cmdWr;
    logic stsWr;
    logic ienWr;
    logic frnWr;
    logic baseWr;
  } strobe_t;

endpackage

// File: rtl/uhc_reg_ctrl.sv
module uhc_reg_ctrl
  import uhc_reg_pkg::*;
#(
  parameter int TICK_CYCLES = 12000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] regAddr,
  input  logic       regWe,
  input  logic       wRun,
  input  logic       wHcReset,
  input  logic       runBit,
  output strobe_t    str
);

  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    str.cmdWr   = regWe && (regAddr == ADR_CMD);
    str.stsWr   = regWe && (regAddr == ADR_STS);
    str.ienWr   = regWe && (regAddr == ADR_IEN);
    str.frnWr   = regWe && (regAddr == ADR_FRN);
    str.baseWr  = regWe && (regAddr == ADR_BASE);
    str.hcReset = str.cmdWr && wHcReset;
    str.runRise = str.cmdWr && wRun && !runBit;
    str.tick    = runBit && (cnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt <= '0;
    else if (str.hcReset || str.runRise || !runBit) cnt <= '0;
    else if (str.tick)                           cnt <= '0;
    else                                         cnt <= cnt + 1'b1;
  end

  generate
    if (TICK_CYCLES > 1) begin : g_gap
      // frame ticks are never back to back (R3)
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        str.tick |=> !str.tick);
    end
  endgenerate

  // a stopped controller restarts its frame count from zero (R3)
  p_idle_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!runBit && !str.runRise) |=> !str.tick);

endmodule

// File: rtl/uhc_reg_dp.sv
module uhc_reg_dp
  import uhc_reg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BASE_LSB   = 12,
  parameter int FRN_W      = 11,
  parameter int ENTRY_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           str,
  input  logic [2:0]        regAddr,
  input  logic [ADDR_W-1:0] wData,
  input  logic              evtComplete,
  input  logic              evtShort,
  input  logic              evtError,
  input  logic              evtResume,
  input  logic              evtSysErr,
  input  logic              evtProcErr,
  output logic [ADDR_W-1:0] rdData,
  output logic [ADDR_W-1:0] frameAddr,
  output logic              irq,
  output logic              runBit
);

  localparam int BASE_W = ADDR_W - BASE_LSB;

  logic [4:0]        cmd, cmdN;
  logic [5:0]        sts, stsN;
  logic [3:0]        ien, ienN;
  logic [FRN_W-1:0]  frn, frnN;
  logic [BASE_W-1:0] base, baseN;
  logic [1:0]        hid, hidN;
  logic [1:0]        pend, pendN;

  always_comb begin
    cmdN  = cmd;
    stsN  = sts;
    ienN  = ien;
    frnN  = frn;
    baseN = base;
    hidN  = hid;
    pendN = pend | {evtShort, evtComplete};

    if (str.cmdWr) begin
      cmdN = wData[4:0];
      cmdN[CMD_HCRST] = 1'b0;
      if (str.runRise)          stsN[STS_HALT] = 1'b0;
      else if (!wData[CMD_RUN]) stsN[STS_HALT] = 1'b1;
    end
    if (evtResume && cmd[CMD_EGS]) begin
      cmdN[CMD_FGR]  = 1'b1;
      stsN[STS_RES]  = 1'b1;
    end

    if (str.stsWr) begin
      stsN[4:0] = stsN[4:0] & ~wData[4:0];
      if (wData[STS_INT]) hidN = 2'b00;
    end
    if (evtError)   stsN[STS_ERR]  = 1'b1;
    if (evtSysErr)  stsN[STS_SYS]  = 1'b1;
    if (evtProcErr) stsN[STS_PROC] = 1'b1;

    if (str.ienWr)  ienN  = wData[3:0];
    if (str.baseWr) baseN = wData[ADDR_W-1:BASE_LSB];

    if (str.tick) begin
      frnN  = frn + 1'b1;
      hidN  = hidN | pend;
      if (pend != 2'b00) stsN[STS_INT] = 1'b1;
      pendN = {evtShort, evtComplete};
    end else if (str.frnWr && sts[STS_HALT]) begin
      frnN = wData[FRN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '0; sts <= STS_RESET; ien <= '0; frn <= '0;
      base <= '0; hid <= '0; pend <= '0;
    end else if (str.hcReset) begin
      cmd <= '0; sts <= STS_RESET; ien <= '0; frn <= '0;
      base <= '0; hid <= '0; pend <= '0;
    end else begin
      cmd <= cmdN; sts <= stsN; ien <= ienN; frn <= frnN;
      base <= baseN; hid <= hidN; pend <= pendN;
    end
  end

  assign runBit    = cmd[CMD_RUN];
  assign frameAddr = {base, {BASE_LSB{1'b0}}}
                   | (ADDR_W'(frn[ENTRY_BITS-1:0]) << 2);
  assign irq = (hid[0] && ien[2]) || (hid[1] && ien[3])
            || (sts[STS_ERR] && ien[0]) || (sts[STS_RES] && ien[1])
            || sts[STS_SYS] || sts[STS_PROC];

  always_comb begin
    case (regAddr)
      ADR_CMD:   rdData = ADDR_W'(cmd);
      ADR_STS:   rdData = ADDR_W'(sts);
      ADR_IEN:   rdData = ADDR_W'(ien);
      ADR_FRN:   rdData = ADDR_W'(frn);
      ADR_BASE:  rdData = {base, {BASE_LSB{1'b0}}};
      ADR_ENTRY: rdData = frameAddr;
      default:   rdData = '0;
    endcase
  end

  // running and halted are mutually exclusive (R2)
  p_run_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[CMD_RUN] != sts[STS_HALT]);

  // each tick moves the frame number by exactly one (R3)
  p_frn_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (str.tick && !str.hcReset) |=> frn == FRN_W'($past(frn) + 1'b1));

  // no frame number change while running other than by a tick (R5)
  p_frn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts[STS_HALT] && !str.tick && !str.hcReset) |=> $stable(frn));

  // pending events are committed at the tick (R4)
  p_pend_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (str.tick && pend != 2'b00 && !str.hcReset) |=> sts[STS_INT]);

  // a hidden cause never outlives the interrupt status bit (R8)
  p_hid_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hid != 2'b00) |-> sts[STS_INT]);

  // fatal errors raise the line without enables (R7)
  p_fatal_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[STS_SYS] || sts[STS_PROC]) |-> irq);

endmodule

// File: rtl/uhc_reg_core.sv
module uhc_reg_core
  import uhc_reg_pkg::*;
#(
  parameter int TICK_CYCLES = 12000,
  parameter int ADDR_W      = 32,
  parameter int BASE_LSB    = 12,
  parameter int FRN_W       = 11,
  parameter int ENTRY_BITS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        regAddr,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              evtComplete,
  input  logic              evtShort,
  input  logic              evtError,
  input  logic              evtResume,
  input  logic              evtSysErr,
  input  logic              evtProcErr,
  output logic [ADDR_W-1:0] frameAddr,
  output logic              frameTick,
  output logic              irq
);

  strobe_t str;
  logic    runBit;

  uhc_reg_ctrl #(.TICK_CYCLES(TICK_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .wRun     (regWdata[CMD_RUN]),
    .wHcReset (regWdata[CMD_HCRST]),
    .runBit   (runBit),
    .str      (str)
  );

  uhc_reg_dp #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB),
    .FRN_W(FRN_W), .ENTRY_BITS(ENTRY_BITS)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .str         (str),
    .regAddr     (regAddr),
    .wData       (regWdata),
    .evtComplete (evtComplete),
    .evtShort    (evtShort),
    .evtError    (evtError),
    .evtResume   (evtResume),
    .evtSysErr   (evtSysErr),
    .evtProcErr  (evtProcErr),
    .rdData      (regRdata),
    .frameAddr   (frameAddr),
    .irq         (irq),
    .runBit      (runBit)
  );

  assign frameTick = str.tick;

endmodule

// File: tb/uhc_reg_core_test.sv
`timescale 1ns/1ps
module uhc_reg_core_test;

  localparam int TICK = 8;
  localparam logic [2:0] A_CMD = 3'd0, A_STS = 3'd1, A_IEN = 3'd2,
                         A_FRN = 3'd3, A_BASE = 3'd4, A_ENT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic evtComplete = 0, evtShort = 0, evtError = 0, evtResume = 0;
  logic evtSysErr = 0, evtProcErr = 0;
  logic [31:0] frameAddr;
  logic        frameTick, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uhc_reg_core #(.TICK_CYCLES(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata),
    .evtComplete(evtComplete), .evtShort(evtShort), .evtError(evtError),
    .evtResume(evtResume), .evtSysErr(evtSysErr), .evtProcErr(evtProcErr),
    .frameAddr(frameAddr), .frameTick(frameTick), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // applied while halted
  localparam vec_t VEC [8] = '{
    '{A_IEN,  32'h0000_000F, A_IEN,  32'h0000_000F, 4'd7},  // R7 enables stored
    '{A_FRN,  32'h0000_FFFF, A_FRN,  32'h0000_07FF, 4'd5},  // R5 11-bit keep
    '{A_BASE, 32'hABCD_E123, A_BASE, 32'hABCD_E000, 4'd6},  // R6 low 12 zero
    '{A_FRN,  32'h0000_07FF, A_ENT,  32'hABCD_EFFC, 4'd6},  // R6 entry
    '{A_FRN,  32'h0000_0405, A_ENT,  32'hABCD_E014, 4'd6},  // R6 low 10 bits only
    '{A_STS,  32'h0000_003F, A_STS,  32'h0000_0020, 4'd2},  // R2 halted read-only
    '{A_CMD,  32'h0000_0008, A_CMD,  32'h0000_0008, 4'd9},  // R9 suspend bit
    '{A_IEN,  32'h0000_0000, A_IEN,  32'h0000_0000, 4'd7}   // R7
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic waitFrame();
    logic [31:0] f0, f1;
    rd(A_FRN, f0);
    for (int i = 0; i < 4 * TICK; i++) begin
      @(posedge clk); @(negedge clk);
      rd(A_FRN, f1);
      if (f1 != f0) break;
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evtComplete = 1; 1: evtShort = 1; 2: evtError = 1;
      3: evtResume = 1;   4: evtSysErr = 1; default: evtProcErr = 1;
    endcase
    @(posedge clk);
    @(negedge clk);
    {evtComplete, evtShort, evtError, evtResume, evtSysErr, evtProcErr} = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, f0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(A_CMD, v);  chk("R1 cmd", v, 32'h0);
    rd(A_STS, v);  chk("R1 sts", v, 32'h20);
    rd(A_IEN, v);  chk("R1 ien", v, 32'h0);
    rd(A_FRN, v);  chk("R1 frn", v, 32'h0);
    rd(A_BASE, v); chk("R1 base", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 / R3 start and exact first tick
    wr(A_CMD, 32'h1);
    rd(A_STS, v); chk("R2 halted cleared", v, 32'h0);
    repeat (TICK - 1) @(posedge clk);
    @(negedge clk); rd(A_FRN, v); chk("R3 before tick", v, 32'h0);
    @(posedge clk); @(negedge clk); rd(A_FRN, v); chk("R3 first tick", v, 32'h1);

    // R4 completion deferred to tick
    wr(A_IEN, 32'h4);
    waitFrame();
    pulse(0);
    rd(A_STS, v); chk("R4 deferred", v, 32'h0);
    chk("R4 irq deferred", {31'b0, irq}, 32'h0);
    waitFrame();
    rd(A_STS, v); chk("R4 committed", v, 32'h1);
    chk("R7 irq complete", {31'b0, irq}, 32'h1);

    // R7 short cause needs its own enable
    wr(A_IEN, 32'h8);
    chk("R7 wrong cause", {31'b0, irq}, 32'h0);
    waitFrame();
    pulse(1);
    waitFrame();
    chk("R4 short irq", {31'b0, irq}, 32'h1);

    // R8 write-one-to-clear interrupt clears hidden cause
    wr(A_STS, 32'h1);
    rd(A_STS, v); chk("R8 int cleared", v, 32'h0);
    wr(A_IEN, 32'hC);
    chk("R8 hidden cleared", {31'b0, irq}, 32'h0);

    // R11 immediate errors, R7 enable gating
    pulse(2);
    rd(A_STS, v); chk("R11 error", v, 32'h2);
    chk("R7 error masked", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h1);
    chk("R7 error enabled", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h2);
    rd(A_STS, v); chk("R8 error cleared", v, 32'h0);
    wr(A_IEN, 32'h0);
    pulse(4);
    rd(A_STS, v); chk("R11 syserr", v, 32'h8);
    chk("R7 syserr no enable", {31'b0, irq}, 32'h1);
    pulse(5);
    rd(A_STS, v); chk("R11 procerr", v, 32'h18);
    wr(A_STS, 32'h18);
    chk("R8 fatal cleared", {31'b0, irq}, 32'h0);

    // R9 resume
    pulse(3);
    rd(A_CMD, v); chk("R9 ignored cmd", v, 32'h1);
    rd(A_STS, v); chk("R9 ignored sts", v, 32'h0);
    wr(A_CMD, 32'h9);
    pulse(3);
    rd(A_CMD, v); chk("R9 force resume", v, 32'h19);
    rd(A_STS, v); chk("R9 resume detect", v, 32'h4);
    wr(A_IEN, 32'h2);
    chk("R7 resume irq", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h4);
    wr(A_IEN, 32'h0);

    // R5 frame write ignored while running
    rd(A_FRN, f0);
    wr(A_FRN, 32'h123);
    rd(A_FRN, v);
    chk("R5 ignored running", {31'b0, (v == f0) || (v == f0 + 1)}, 32'h1);

    // R2 stop, R3 frozen when stopped
    wr(A_CMD, 32'h0);
    rd(A_STS, v); chk("R2 halted set", v, 32'h20);
    rd(A_FRN, f0);
    repeat (3 * TICK) @(posedge clk);
    @(negedge clk); rd(A_FRN, v); chk("R3 frozen", v, f0);

    // table of halted register accesses
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, v);
      checks++;
      if (v !== VEC[i].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d: got 0x%08h expected 0x%08h",
                 VEC[i].req, i, v, VEC[i].exp);
      end
    end

    // R3 wrap and R6 entry address at wrap
    wr(A_FRN, 32'h7FF);
    chk("R6 port entry", frameAddr, 32'hABCD_EFFC);
    wr(A_CMD, 32'h1);
    waitFrame();
    rd(A_FRN, v); chk("R3 wrap", v, 32'h0);
    chk("R6 entry after wrap", frameAddr, 32'hABCD_E000);

    // R10 host controller reset
    wr(A_IEN, 32'hF);
    pulse(4);
    wr(A_CMD, 32'h2);
    rd(A_CMD, v);  chk("R10 cmd", v, 32'h0);
    rd(A_STS, v);  chk("R10 sts", v, 32'h20);
    rd(A_IEN, v);  chk("R10 ien", v, 32'h0);
    rd(A_FRN, v);  chk("R10 frn", v, 32'h0);
    rd(A_BASE, v); chk("R10 base", v, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule